// File: doc/BRIEF.md
# Parallel Header Range Filter

This block screens packet headers against a small bank of rules held side by side. Each header arrives as a one-cycle strobe together with its source and destination IPv4 addresses and its source and destination ports. Every rule slot compares the header with its own stored rule at the same time. The per-slot results are merged into a single discard decision, which goes back to whichever unit supplied the header. That unit keeps processing the packet through its usual path while the check runs, and it throws the packet away when the decision says so.

A rule is either a permit rule or a deny rule. It covers an inclusive range of IPv4 addresses and an inclusive range of ports. It looks at either the source pair or the destination pair of the header. Rules are written one slot at a time through a plain write port, and a slot can be switched off by rewriting it with its enable bit cleared. Any deny rule that matches forces a discard. Once at least one permit rule is enabled, a header must also match some permit rule to be kept.

Top module: `hdr_range_filter`

## Requirements
- R1: During reset and in the first cycles after it, `verdict_vld` and `verdict_drop` are 0, and every rule slot is disabled.
- R2: For every cycle in which `hdr_vld` is 1, `verdict_vld` is 1 exactly one clock later. A header may be presented on every cycle, and `verdict_vld` is 0 in any cycle that does not follow a header.
- R3: A rule matches when its selected address lies within [ip_lo, ip_hi] and its selected port lies within [port_lo, port_hi], with both bounds inclusive. With `cfg_use_dst`=0 the rule compares `src_ip`/`src_port`. With `cfg_use_dst`=1 it compares `dst_ip`/`dst_port`.
- R4: An enabled rule with `cfg_deny`=1 that matches the header makes `verdict_drop` 1.
- R5: When at least one enabled rule has `cfg_deny`=0, a header that matches none of those permit rules is dropped. A header that matches a permit rule, and no deny rule, is kept (`verdict_drop`=0).
- R6: A matching deny rule wins over a matching permit rule.
- R7: Slots with `cfg_en`=0 take no part in the decision. With no slot enabled, no header is dropped.
- R8: A rule written in the same cycle as a header does not affect that header. It affects headers from the next cycle onward.
- R9: A write with `cfg_we`=1 replaces the whole rule of slot `cfg_idx` (slots numbered 0 to N_RULES-1). Writing a slot with `cfg_en`=0 disables it.
- R10: `verdict_drop` is 0 whenever `verdict_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_vld | input | 1 | Header strobe |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | 3 | Slot to write |
| cfg_en | input | 1 | Rule enabled |
| cfg_deny | input | 1 | 1 = deny range, 0 = permit range |
| cfg_use_dst | input | 1 | 1 = compare destination fields, 0 = source fields |
| cfg_ip_lo | input | 32 | Lowest address in range |
| cfg_ip_hi | input | 32 | Highest address in range |
| cfg_port_lo | input | 16 | Lowest port in range |
| cfg_port_hi | input | 16 | Highest port in range |
| verdict_vld | output | 1 | Decision strobe, one cycle after `hdr_vld` |
| verdict_drop | output | 1 | 1 = discard the packet |

## Verification
The assertions check several properties on every cycle. They confirm the one-cycle pairing of header strobe and decision, and that `verdict_drop` never appears without `verdict_vld`. They confirm that a header meeting a matching deny slot, or missing every enabled permit slot, gets a drop, that an empty rule bank never drops, and that a write loads its slot on the next edge. Other behaviour is shown only by the bench scenarios. These cover exact boundary values of the address and port ranges, the choice between source and destination fields, the ordering between a rule write and a header in the same cycle, and disabling a slot by rewriting it.

// File: rtl/hdr_filter_pkg.sv
`timescale 1ns/1ps
package hdr_filter_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned PORT_W = 16;

  typedef struct packed {
    logic              en;
    logic              deny;
    logic              use_dst;
    logic [ADDR_W-1:0] ip_lo;
    logic [ADDR_W-1:0] ip_hi;
    logic [PORT_W-1:0] port_lo;
    logic [PORT_W-1:0] port_hi;
  } rule_t;

  localparam rule_t RULE_OFF = '{default: '0};
endpackage

// File: rtl/filt_rst_sync.sv
`timescale 1ns/1ps
module filt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/filt_rule_slot.sv
`timescale 1ns/1ps
module filt_rule_slot
  import hdr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              wr_en,
  input  rule_t             wr_rule,
  input  logic [ADDR_W-1:0] src_ip,
  input  logic [ADDR_W-1:0] dst_ip,
  input  logic [PORT_W-1:0] src_port,
  input  logic [PORT_W-1:0] dst_port,
  output logic              slot_en,
  output logic              slot_deny,
  output logic              slot_hit
);
  rule_t rule_q, rule_d;

  // next-state: load on write enable, hold otherwise
  always_comb begin
    rule_d = rule_q;
    if (wr_en) rule_d = wr_rule;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rule_q <= RULE_OFF;
    else         rule_q <= rule_d;
  end

  // range comparator on the selected field pair
  logic [ADDR_W-1:0] cmp_ip;
  logic [PORT_W-1:0] cmp_port;
  logic              ip_in, port_in;

  always_comb begin
    cmp_ip   = rule_q.use_dst ? dst_ip   : src_ip;
    cmp_port = rule_q.use_dst ? dst_port : src_port;
    ip_in    = (cmp_ip   >= rule_q.ip_lo)   && (cmp_ip   <= rule_q.ip_hi);
    port_in  = (cmp_port >= rule_q.port_lo) && (cmp_port <= rule_q.port_hi);
  end

  assign slot_en   = rule_q.en;
  assign slot_deny = rule_q.deny;
  assign slot_hit  = rule_q.en && ip_in && port_in;

  // R9: a write replaces the slot contents at the next edge
  a_r9_slot_load: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |=> (rule_q == $past(wr_rule)));
endmodule

// File: rtl/filt_merge.sv
`timescale 1ns/1ps
module filt_merge #(
  parameter int unsigned N_RULES = 8
) (
  input  logic [N_RULES-1:0] en_vec,
  input  logic [N_RULES-1:0] deny_vec,
  input  logic [N_RULES-1:0] hit_vec,
  output logic               drop_c
);
  logic [N_RULES-1:0] permit_vec;
  logic deny_hit, permit_any, permit_hit;

  always_comb begin
    permit_vec = en_vec & ~deny_vec;
    deny_hit   = |(hit_vec & deny_vec);
    permit_any = |permit_vec;
    permit_hit = |(hit_vec & permit_vec);
    drop_c     = deny_hit || (permit_any && !permit_hit);
  end
endmodule

// File: rtl/hdr_range_filter.sv
`timescale 1ns/1ps
module hdr_range_filter
  import hdr_filter_pkg::*;
#(
  parameter int unsigned N_RULES = 8,
  localparam int unsigned IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_vld,
  input  logic [ADDR_W-1:0] src_ip,
  input  logic [ADDR_W-1:0] dst_ip,
  input  logic [PORT_W-1:0] src_port,
  input  logic [PORT_W-1:0] dst_port,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic              cfg_deny,
  input  logic              cfg_use_dst,
  input  logic [ADDR_W-1:0] cfg_ip_lo,
  input  logic [ADDR_W-1:0] cfg_ip_hi,
  input  logic [PORT_W-1:0] cfg_port_lo,
  input  logic [PORT_W-1:0] cfg_port_hi,
  output logic              verdict_vld,
  output logic              verdict_drop
);
  logic rst_ns;

  filt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  rule_t wr_rule;
  always_comb begin
    wr_rule.en      = cfg_en;
    wr_rule.deny    = cfg_deny;
    wr_rule.use_dst = cfg_use_dst;
    wr_rule.ip_lo   = cfg_ip_lo;
    wr_rule.ip_hi   = cfg_ip_hi;
    wr_rule.port_lo = cfg_port_lo;
    wr_rule.port_hi = cfg_port_hi;
  end

  logic [N_RULES-1:0] en_vec, deny_vec, hit_vec;

  for (genvar g = 0; g < N_RULES; g++) begin : g_slot
    logic sel_we;
    assign sel_we = cfg_we && (cfg_idx == IDX_W'(g));
    filt_rule_slot u_slot (
      .clk       (clk),
      .rst_ns    (rst_ns),
      .wr_en     (sel_we),
      .wr_rule   (wr_rule),
      .src_ip    (src_ip),
      .dst_ip    (dst_ip),
      .src_port  (src_port),
      .dst_port  (dst_port),
      .slot_en   (en_vec[g]),
      .slot_deny (deny_vec[g]),
      .slot_hit  (hit_vec[g])
    );
  end

  logic drop_c;
  filt_merge #(.N_RULES(N_RULES)) u_merge (
    .en_vec   (en_vec),
    .deny_vec (deny_vec),
    .hit_vec  (hit_vec),
    .drop_c   (drop_c)
  );

  // verdict register: next-state and storage kept apart
  logic vld_d, drop_d, vld_q, drop_q;

  always_comb begin
    vld_d  = hdr_vld;
    drop_d = hdr_vld && drop_c;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      drop_q <= drop_d;
    end
  end

  assign verdict_vld  = vld_q;
  assign verdict_drop = drop_q;

  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_ns)
    hdr_vld |=> verdict_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_ns)
    !hdr_vld |=> !verdict_vld);
  a_r10_drop_qualified: assert property (@(posedge clk) disable iff (!rst_ns)
    verdict_drop |-> verdict_vld);
  a_r7_empty_bank_passes: assert property (@(posedge clk) disable iff (!rst_ns)
    (hdr_vld && (en_vec == '0)) |=> !verdict_drop);
  a_r4_deny_forces: assert property (@(posedge clk) disable iff (!rst_ns)
    (hdr_vld && |(hit_vec & deny_vec)) |=> verdict_drop);
  a_r5_permit_miss: assert property (@(posedge clk) disable iff (!rst_ns)
    (hdr_vld && |(en_vec & ~deny_vec) && !(|(hit_vec & ~deny_vec))) |=> verdict_drop);
endmodule

// File: tb/sim_hdr_range_filter.sv
`timescale 1ns/1ps
module sim_hdr_range_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hdr_vld;
  logic [31:0] src_ip, dst_ip;
  logic [15:0] src_port, dst_port;
  logic        cfg_we, cfg_en, cfg_deny, cfg_use_dst;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_ip_lo, cfg_ip_hi;
  logic [15:0] cfg_port_lo, cfg_port_hi;
  logic        verdict_vld, verdict_drop;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  hdr_range_filter u0 (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld),
    .src_ip(src_ip), .dst_ip(dst_ip), .src_port(src_port), .dst_port(dst_port),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_deny(cfg_deny),
    .cfg_use_dst(cfg_use_dst), .cfg_ip_lo(cfg_ip_lo), .cfg_ip_hi(cfg_ip_hi),
    .cfg_port_lo(cfg_port_lo), .cfg_port_hi(cfg_port_hi),
    .verdict_vld(verdict_vld), .verdict_drop(verdict_drop)
  );

  // {src_ip, dst_ip, src_port, dst_port, expected drop}
  localparam int NV = 11;
  localparam logic [96:0] VEC [NV] = '{
    {32'h0B000001, 32'hC0A80001, 16'd1000, 16'd80,  1'b0}, // R3 port low bound
    {32'h0B000001, 32'hC0A80001, 16'd1000, 16'd443, 1'b0}, // R3 port high bound
    {32'h0B000001, 32'hC0A80001, 16'd1000, 16'd444, 1'b1}, // R5 above range
    {32'h0B000001, 32'hC0A80001, 16'd1000, 16'd79,  1'b1}, // R5 below range
    {32'h0A000010, 32'hC0A80001, 16'd1000, 16'd100, 1'b1}, // R6 deny over permit
    {32'h0A0000FF, 32'h08080808, 16'd7,    16'd53,  1'b1}, // R4 deny at upper bound
    {32'h0A000100, 32'h08080808, 16'd7,    16'd53,  1'b0}, // R4 just past deny
    {32'h09FFFFFF, 32'h08080809, 16'd7,    16'd53,  1'b1}, // R5 single-address miss
    {32'h0B000001, 32'hC0A7FFFF, 16'd1000, 16'd100, 1'b1}, // R3 ip below range
    {32'h0B000001, 32'hC0A8FFFF, 16'd1000, 16'd100, 1'b0}, // R3 ip high bound
    {32'hC0A80001, 32'h01010101, 16'd80,   16'd9,   1'b1}  // R3 field select
  };

  task automatic check(input string req, input logic vld, input logic drop,
                       input logic exp_vld, input logic exp_drop);
    nvec++;
    if (vld !== exp_vld || drop !== exp_drop) begin
      nbad++;
      $display("FAIL %s: vld/drop actual %b/%b expected %b/%b", req, vld, drop, exp_vld, exp_drop);
    end
  endtask

  task automatic set_hdr(input logic v, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] sp, input logic [15:0] dp);
    hdr_vld = v; src_ip = s; dst_ip = d; src_port = sp; dst_port = dp;
  endtask

  task automatic set_cfg(input logic we, input logic [2:0] idx, input logic en,
                         input logic deny, input logic usedst,
                         input logic [31:0] ilo, input logic [31:0] ihi,
                         input logic [15:0] plo, input logic [15:0] phi);
    cfg_we = we; cfg_idx = idx; cfg_en = en; cfg_deny = deny; cfg_use_dst = usedst;
    cfg_ip_lo = ilo; cfg_ip_hi = ihi; cfg_port_lo = plo; cfg_port_hi = phi;
  endtask

  task automatic write_rule(input logic [2:0] idx, input logic en, input logic deny,
                            input logic usedst, input logic [31:0] ilo, input logic [31:0] ihi,
                            input logic [15:0] plo, input logic [15:0] phi);
    @(negedge clk);
    set_cfg(1'b1, idx, en, deny, usedst, ilo, ihi, plo, phi);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_hdr(1'b0, '0, '0, '0, '0);
    set_cfg(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    check("R1 in reset", verdict_vld, verdict_drop, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", verdict_vld, verdict_drop, 1'b0, 1'b0);

    // R7: empty bank, a header in a deny-looking range is kept
    set_hdr(1'b1, 32'h0A000001, 32'h0A000002, 16'd1, 16'd2);
    @(negedge clk);
    check("R7 empty bank", verdict_vld, verdict_drop, 1'b1, 1'b0);
    set_hdr(1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check("R10 idle cycle", verdict_vld, verdict_drop, 1'b0, 1'b0);

    // R8: deny-all written in the same cycle as a header
    set_cfg(1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 32'h0, 32'hFFFFFFFF, 16'h0, 16'hFFFF);
    set_hdr(1'b1, 32'h01020304, 32'h05060708, 16'd9, 16'd10);
    @(negedge clk);
    check("R8 same-cycle write", verdict_vld, verdict_drop, 1'b1, 1'b0);
    cfg_we = 1'b0;
    @(negedge clk);
    check("R8 next header", verdict_vld, verdict_drop, 1'b1, 1'b1);
    hdr_vld = 1'b0;

    // R9: disable slot 3 by rewriting it
    write_rule(3'd3, 1'b0, 1'b1, 1'b0, 32'h0, 32'hFFFFFFFF, 16'h0, 16'hFFFF);
    hdr_vld = 1'b1;
    @(negedge clk);
    check("R9 slot disabled", verdict_vld, verdict_drop, 1'b1, 1'b0);
    hdr_vld = 1'b0;

    // rule set for the table
    write_rule(3'd0, 1'b1, 1'b1, 1'b0, 32'h0A000000, 32'h0A0000FF, 16'd0,  16'hFFFF);
    write_rule(3'd1, 1'b1, 1'b0, 1'b1, 32'hC0A80000, 32'hC0A8FFFF, 16'd80, 16'd443);
    write_rule(3'd2, 1'b1, 1'b0, 1'b1, 32'h08080808, 32'h08080808, 16'd53, 16'd53);

    // R2: headers back to back, verdict for vector i checked one cycle later
    for (int i = 0; i <= NV; i++) begin
      if (i < NV) set_hdr(1'b1, VEC[i][96:65], VEC[i][64:33], VEC[i][32:17], VEC[i][16:1]);
      else        hdr_vld = 1'b0;
      @(negedge clk);
      if (i < NV) check("R2/R3/R4/R5/R6 table", verdict_vld, verdict_drop, 1'b1, VEC[i][0]);
    end
    check("R2 after burst", verdict_vld, verdict_drop, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule